// File: doc/BRIEF.md
# External Memory Bus Controller

This block is a bus master that turns single internal read and write requests into cycles on an external asynchronous memory bus. The bus carries 16 data bits and a halfword address. The block stretches each external access to a programmed number of bus clocks. An optional external wait input can hold the access open for longer than that. The requester raises `reqValid` while `reqReady` is high. It gets one `done` pulse when the access ends. Read data is valid on `rdData` from that pulse onward.

A mode input picks one of two signalling styles. The normal style uses separate upper and lower lane selects and separate read and write enables. The alternate style drives address bit 0, a low-byte select and one read/write line. In the alternate style an access to an internal resource is also shown on the external bus as a one-cycle cycle. A write of that kind is driven onto the bus as well. In the normal style the same internal access causes no bus activity.

Top module: `extBusCtrl`

## Requirements
- R1: After reset `reqReady` is 1, and `done`, `busValid`, `busDataOe`, `laneHi`, `laneLo`, `rdEnable`, `wrEnable` and `lowSel` are all 0, while `rwLine` is 1.
- R2: With waiting disabled, an external access keeps `busValid` high for exactly `cfgStretch`+2 consecutive cycles, so the length runs from 2 to 9.
- R3: With waiting enabled, `extWait` passes through two synchronising flops. If `extWait` goes low during access cycle j, the access lasts max(`cfgStretch`+2, 3, j+2) cycles. While `extWait` stays high the access does not end.
- R4: With waiting enabled and `extWait` low, an access lasts max(`cfgStretch`+2, 3) cycles, which is never fewer than 3.
- R5: Normal style, during access cycles. A word access (`reqByte`=0) raises both `laneHi` and `laneLo`. A byte access raises only `laneHi` when `reqAddr[0]`=0 and only `laneLo` when `reqAddr[0]`=1.
- R6: Normal style, during access cycles. `rdEnable` is high for reads and `wrEnable` is high for writes. `busAddr[22:1]` equals `reqAddr[22:1]` and `busAddr[0]` is 0. `lowSel` is 0 and `rwLine` is 1.
- R7: Alternate style, during access cycles. `busAddr[0]` is `reqAddr[0]` for byte accesses and 0 for word accesses. `lowSel` is 1 for a word access or an odd byte and 0 for an even byte. `rwLine` is 1 for a read and 0 for a write. `laneHi`, `laneLo`, `rdEnable` and `wrEnable` stay 0.
- R8: An internal access (`reqInternal`=1) ends after one cycle. In the alternate style it raises `busValid` for that one cycle, and if it is a write it drives `busDataOut`. In the normal style it causes no bus activity.
- R9: For a write that reaches the bus, `busDataOe` is high from the first access cycle through the `done` cycle, then low. `busDataOut` equals `reqWdata`. `busDataOe` is never high during a read.
- R10: For an external read, `rdData` takes the value on `busDataIn` in the last access cycle and shows it from the `done` cycle onward.
- R11: `done` is a one-cycle pulse in the cycle after the last access cycle. `reqReady` is high only when the block is idle. A request raised while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = byte access, 0 = word access |
| reqInternal | input | 1 | Access targets an internal resource |
| reqAddr | input | 23 | Byte address |
| reqWdata | input | 16 | Write data |
| cfgStretch | input | 3 | Stretch code; access length is code+2 |
| cfgWaitEn | input | 1 | Enables the external wait input |
| cfgAltMode | input | 1 | 1 = alternate signalling style |
| extWait | input | 1 | External wait, high holds the access open |
| busDataIn | input | 16 | Data bus input side |
| reqReady | output | 1 | Block idle, request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read data |
| busValid | output | 1 | High in every bus access cycle |
| busAddr | output | 23 | External address; bit 0 used only in the alternate style |
| busDataOut | output | 16 | Data bus output side |
| busDataOe | output | 1 | Data bus output enable |
| laneHi | output | 1 | Upper lane select (normal style) |
| laneLo | output | 1 | Lower lane select (normal style) |
| rdEnable | output | 1 | Read enable (normal style) |
| wrEnable | output | 1 | Write enable (normal style) |
| lowSel | output | 1 | Low-byte select (alternate style) |
| rwLine | output | 1 | Read/write line, 1 = read (alternate style) |

## Verification
The checker watches every cycle for several properties. Normal-style accesses must never be shorter than the programmed stretch, and never shorter than three cycles when waiting is enabled. The read and write enables must not be high together, and the output drivers must not be on during a read. The alternate style must keep the normal-style pins quiet. `done` must stay one cycle long and never coincide with `reqReady`. Only the bench scenarios can show the exact access length, the two-flop delay on the wait release, the lane and address-bit encodings, last-cycle read capture, the release of the drivers one cycle late, and that a request made while busy is dropped.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef struct packed {
    logic load;     // latch the request
    logic busOn;    // bus access cycle visible on the pins
    logic capture;  // sample read data this cycle
    logic drive;    // write drivers may be on
  } ebcStrobes_t;
endpackage

// File: rtl/ebcSync.sv
module ebcSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ebcControl.sv
module ebcControl
  import ebc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int WAIT_FLOOR = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqInternal,
  input  logic        reqWrite,
  input  logic [2:0]  cfgStretch,
  input  logic        cfgWaitEn,
  input  logic        cfgAltMode,
  input  logic        waitSync,
  output logic        reqReady,
  output logic        done,
  output ebcStrobes_t strb
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FLOOR   = CNT_W'(WAIT_FLOOR);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_FIN} state_t;
  state_t state;
  logic [CNT_W-1:0] cnt;
  logic isInt, isWr;
  logic [CNT_W-1:0] stretchLen;
  logic lastCyc, quiet;

  assign stretchLen = CNT_W'(cfgStretch) + CNT_W'(2);
  assign quiet      = isInt & ~cfgAltMode;
  assign lastCyc    = isInt | ((cnt >= stretchLen) &&
                      (!cfgWaitEn || ((cnt >= FLOOR) && !waitSync)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isInt <= 1'b0;
      isWr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_ACT;
          cnt   <= CNT_W'(1);
          isInt <= reqInternal;
          isWr  <= reqWrite;
        end
        ST_ACT: begin
          if (lastCyc) state <= ST_FIN;
          else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign done         = (state == ST_FIN);
  assign strb.load    = reqReady & reqValid;
  assign strb.busOn   = (state == ST_ACT) & ~quiet;
  assign strb.capture = (state == ST_ACT) & lastCyc & ~isInt & ~isWr;
  assign strb.drive   = ((state == ST_ACT) | (state == ST_FIN)) & ~quiet;
endmodule

// File: rtl/ebcDatapath.sv
module ebcDatapath
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ebcStrobes_t       strb,
  input  logic              cfgAltMode,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              laneHi,
  output logic              laneLo,
  output logic              rdEnable,
  output logic              wrEnable,
  output logic              lowSel,
  output logic              rwLine
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic wrQ, byteQ;
  logic normOn, altOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wrQ    <= 1'b0;
      byteQ  <= 1'b0;
      rdData <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        wrQ    <= reqWrite;
        byteQ  <= reqByte;
      end
      if (strb.capture) rdData <= busDataIn;
    end
  end

  assign normOn     = strb.busOn & ~cfgAltMode;
  assign altOn      = strb.busOn & cfgAltMode;
  assign busValid   = strb.busOn;
  assign busAddr    = {addrQ[ADDR_W-1:1], cfgAltMode & byteQ & addrQ[0]};
  assign busDataOut = wdataQ;
  assign busDataOe  = strb.drive & wrQ;
  assign laneHi     = normOn & (~byteQ | ~addrQ[0]);
  assign laneLo     = normOn & (~byteQ | addrQ[0]);
  assign rdEnable   = normOn & ~wrQ;
  assign wrEnable   = normOn & wrQ;
  assign lowSel     = altOn & (~byteQ | addrQ[0]);
  assign rwLine     = ~(altOn & wrQ);
endmodule

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic              reqInternal,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [2:0]        cfgStretch,
  input  logic              cfgWaitEn,
  input  logic              cfgAltMode,
  input  logic              extWait,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              laneHi,
  output logic              laneLo,
  output logic              rdEnable,
  output logic              wrEnable,
  output logic              lowSel,
  output logic              rwLine
);
  ebcStrobes_t strb;
  logic waitSync;

  ebcSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(extWait), .dout(waitSync));

  ebcControl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqInternal(reqInternal),
    .reqWrite(reqWrite), .cfgStretch(cfgStretch), .cfgWaitEn(cfgWaitEn),
    .cfgAltMode(cfgAltMode), .waitSync(waitSync), .reqReady(reqReady),
    .done(done), .strb(strb));

  ebcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgAltMode(cfgAltMode),
    .reqWrite(reqWrite), .reqByte(reqByte), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busDataIn(busDataIn), .rdData(rdData),
    .busValid(busValid), .busAddr(busAddr), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .laneHi(laneHi), .laneLo(laneLo),
    .rdEnable(rdEnable), .wrEnable(wrEnable), .lowSel(lowSel),
    .rwLine(rwLine));
endmodule

// File: rtl/extBusCtrlChecker.sv
module extBusCtrlChecker (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic       reqReady,
  input logic       busValid,
  input logic       busDataOe,
  input logic       laneHi,
  input logic       laneLo,
  input logic       rdEnable,
  input logic       wrEnable,
  input logic [2:0] cfgStretch,
  input logic       cfgWaitEn,
  input logic       cfgAltMode
);
  logic [4:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (busValid) runLen <= (runLen == 5'd31) ? runLen : runLen + 5'd1;
    else runLen <= '0;
  end

  AST_STRETCH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busValid) && !cfgAltMode) |-> (runLen >= {2'b0, cfgStretch} + 5'd2)); // R2
  AST_WAIT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busValid) && !cfgAltMode && cfgWaitEn) |-> (runLen >= 5'd3)); // R4
  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEnable && wrEnable)); // R6
  AST_ALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cfgAltMode |-> !(laneHi || laneLo || rdEnable || wrEnable)); // R7
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> !rdEnable); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqReady); // R11
endmodule

bind extBusCtrl extBusCtrlChecker uChk (
  .clk(clk), .rstN(rstN), .done(done), .reqReady(reqReady),
  .busValid(busValid), .busDataOe(busDataOe), .laneHi(laneHi),
  .laneLo(laneLo), .rdEnable(rdEnable), .wrEnable(wrEnable),
  .cfgStretch(cfgStretch), .cfgWaitEn(cfgWaitEn), .cfgAltMode(cfgAltMode));

// File: tb/sim_extBusCtrl.sv
module sim_extBusCtrl;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, reqByte = 0, reqInternal = 0;
  logic [22:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, busDataIn = '0;
  logic [2:0]  cfgStretch = '0;
  logic cfgWaitEn = 0, cfgAltMode = 0, extWait = 0;
  logic reqReady, done, busValid, busDataOe, laneHi, laneLo;
  logic rdEnable, wrEnable, lowSel, rwLine;
  logic [15:0] rdData, busDataOut;
  logic [22:0] busAddr;

  int checks = 0, errors = 0;
  always #2.5 clk = ~clk;

  extBusCtrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // results of the last access
  int          gLen;
  logic        gHi, gLo, gRd, gWr, gLow, gRw, gA0, gOe, gOeDone, gOeAfter, gReadyAfter;
  logic [21:0] gAddrHi;
  logic [15:0] gOut, gRdData;

  task automatic runAcc(input logic alt, input logic wr, input logic byteA,
                        input logic intl, input logic [22:0] addr,
                        input logic [15:0] data, input logic [2:0] st,
                        input logic wEn, input int dropAt, input int expLen);
    int guard;
    @(negedge clk);
    cfgAltMode = alt; cfgStretch = st; cfgWaitEn = wEn;
    reqValid = 1; reqWrite = wr; reqByte = byteA; reqInternal = intl;
    reqAddr = addr; reqWdata = data; busDataIn = ~data;
    gLen = 0; gOe = 0; guard = 0;
    @(negedge clk);
    reqValid = 0;
    while (!done && guard < 100) begin
      guard++;
      if (busValid) begin
        gLen++;
        if (gLen == 1) begin
          gHi = laneHi; gLo = laneLo; gRd = rdEnable; gWr = wrEnable;
          gLow = lowSel; gRw = rwLine; gA0 = busAddr[0];
          gAddrHi = busAddr[22:1]; gOut = busDataOut; gOe = busDataOe;
        end
        if (gLen == dropAt) extWait = 0;
        busDataIn = (gLen == expLen) ? data : ~data;
      end
      @(negedge clk);
    end
    gOeDone = busDataOe; gRdData = rdData;
    @(negedge clk);
    gOeAfter = busDataOe; gReadyAfter = reqReady;
  endtask

  typedef struct packed {
    logic alt, wr, byteA;
    logic [22:0] addr;
    logic [15:0] data;
    logic [2:0] st;
    logic e0, e1;   // normal: laneHi/laneLo ; alt: busAddr[0]/lowSel
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 23'h12346, 16'hA55A, 3'd0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 23'h00010, 16'h1234, 3'd3, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 23'h7FFFF1, 16'hBEEF, 3'd7, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 23'h00FF3, 16'h0F0F, 3'd1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b1, 23'h20002, 16'hC3C3, 3'd2, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 23'h20005, 16'h5AA5, 3'd5, 1'b1, 1'b1}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", reqReady, 1); chk("R1 done", done, 0);
    chk("R1 busValid", busValid, 0); chk("R1 oe", busDataOe, 0);
    chk("R1 strobes", {laneHi, laneLo, rdEnable, wrEnable, lowSel}, 0);
    chk("R1 rwLine", rwLine, 1);
    rstN = 1;
    @(negedge clk);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      runAcc(v.alt, v.wr, v.byteA, 0, v.addr, v.data, v.st, 0, 0, v.st + 2);
      chk("R2 length", gLen, v.st + 2);
      chk("R6 addr hi", gAddrHi, v.addr[22:1]);
      chk("R11 ready after", gReadyAfter, 1);
      if (!v.alt) begin
        chk("R5 laneHi", gHi, v.e0); chk("R5 laneLo", gLo, v.e1);
        chk("R6 rdEnable", gRd, !v.wr); chk("R6 wrEnable", gWr, v.wr);
        chk("R6 addr0", gA0, 0); chk("R6 lowSel", gLow, 0); chk("R6 rwLine", gRw, 1);
      end else begin
        chk("R7 addr0", gA0, v.e0); chk("R7 lowSel", gLow, v.e1);
        chk("R7 rwLine", gRw, !v.wr);
        chk("R7 normal pins", {gHi, gLo, gRd, gWr}, 0);
      end
      if (v.wr) begin
        chk("R9 oe first", gOe, 1); chk("R9 oe done", gOeDone, 1);
        chk("R9 oe after", gOeAfter, 0); chk("R9 data", gOut, v.data);
      end else begin
        chk("R9 oe on read", gOe, 0);
        chk("R10 read capture", gRdData, v.data);
      end
    end

    // R4 wait enabled, wait low: floor of 3
    extWait = 0;
    runAcc(0, 0, 0, 0, 23'h400, 16'h1111, 3'd0, 1, 0, 3);
    chk("R4 floor", gLen, 3);
    chk("R10 capture floor", gRdData, 16'h1111);
    runAcc(0, 0, 0, 0, 23'h400, 16'h2222, 3'd4, 1, 0, 6);
    chk("R4 stretch above floor", gLen, 6);

    // R3 wait held then released in cycle 5: length 7
    extWait = 1; repeat (3) @(negedge clk);
    runAcc(0, 0, 0, 0, 23'h500, 16'h3333, 3'd1, 1, 5, 7);
    chk("R3 wait release", gLen, 7);
    chk("R10 capture after wait", gRdData, 16'h3333);
    // R3 release early: programmed stretch dominates
    extWait = 1; repeat (3) @(negedge clk);
    runAcc(0, 0, 0, 0, 23'h500, 16'h4444, 3'd6, 1, 2, 8);
    chk("R3 stretch dominates", gLen, 8);
    extWait = 0;

    // R8 internal accesses
    runAcc(1, 1, 0, 1, 23'h600, 16'h7777, 3'd7, 0, 0, 1);
    chk("R8 alt mirror length", gLen, 1);
    chk("R8 alt mirror oe", gOe, 1);
    chk("R8 alt mirror data", gOut, 16'h7777);
    runAcc(0, 1, 0, 1, 23'h600, 16'h8888, 3'd7, 0, 0, 1);
    chk("R8 normal internal quiet", gLen, 0);
    chk("R8 normal internal no oe", gOeDone, 0);

    // R11 request while busy is ignored
    @(negedge clk);
    cfgAltMode = 0; cfgStretch = 3'd2; cfgWaitEn = 0;
    reqValid = 1; reqWrite = 0; reqByte = 0; reqInternal = 0; reqAddr = 23'h100;
    @(negedge clk);
    reqValid = 0;
    chk("R11 busy not ready", reqReady, 0);
    @(negedge clk);
    reqValid = 1; reqAddr = 23'h200;
    @(negedge clk);
    reqValid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    repeat (2) @(negedge clk);
    chk("R11 busy request dropped", busValid, 0);
    chk("R11 idle ready", reqReady, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule